// File: doc/BRIEF.md
# Configurable TDM Audio Slot Receiver

This block receives a serial audio stream in which the bit clock and the frame sync are supplied from outside; it only observes them and never drives them. It runs on a fast system clock. The bit clock, frame sync and serial data are brought into that domain through synchronizers, and the rising edge of the bit clock is detected there. The bit clock must therefore run at no more than a quarter of the system clock.

A four-bit format code selects the framing style and whether the stream is two-channel or multi-slot (TDM). In TDM mode each of the four output channels takes its word from an independently programmed byte offset inside a frame of up to 512 bits. In two-channel mode the even outputs carry the first slot and the odd outputs carry the second.

At the start of each frame, the four words captured during the previous frame are presented together and a one-cycle valid pulse is raised. Word length, slot width, offsets and mode are taken at the frame boundary. Rewriting them in the middle of a frame therefore only affects the next frame.

Top module: `tdm_slot_rx`

## Requirements
- R1: While reset is high and after it is released, every output sample is zero and the valid output is low until the first complete frame has been received.
- R2: Format codes: 8 starts a frame on a falling frame-sync edge; 9 (left-justified), 10 (right-justified), 11 and 12 (pulse with late data), and 3 and 4 (pulse with data on the pulse) start a frame on a rising frame-sync edge. Edges are sampled on rising bit-clock edges.
- R3: Bit 0 of a frame is sampled one bit clock after the start edge for codes 8, 11 and 12, and on the start edge itself for codes 9, 10, 3 and 4.
- R4: Any other format code starts no frame. No valid pulse is raised and the outputs keep their values.
- R5: The word-length field selects 0 = 16, 1 = 18, 2 = 20 or 3 = 32 bits, limited to the slot width; a 24-bit slot with code 3 gives 24 bits.
- R6: The slot-width field selects 0 = 16, 1 = 24, and 2 or 3 = 32 bits.
- R7: In TDM mode (codes 12 and 4), channel k takes its word from bit index 8 × offset_k, where offset_k is bits [6k+5:6k] of the offset bus. Several channels may share one offset.
- R8: In two-channel mode (codes 8, 9, 10, 11 and 3), channels 0 and 2 take slot 0 and channels 1 and 3 take slot 1, and the offsets are ignored.
- R9: Words are received MSB first. A word shorter than its slot sits at the start of the slot, except for code 10, where its last bit is the last bit of the slot.
- R10: Each output sample is 32 bits wide, sample k at bits [32k+31:32k], with the word MSB-aligned and zeros below it. All four samples change together with a one-cycle valid pulse, three system-clock edges after the bit-clock rise that carries bit 0 of the next frame, and they hold at all other times.
- R11: Offsets, word length, slot width and mode written in the middle of a frame take effect from the next frame only.
- R12: A 512-bit frame is handled in full, including a word at byte offset 60 in the last 32-bit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | System clock |
| i_rst | input | 1 | Synchronous active-high reset |
| i_bclk | input | 1 | Serial bit clock (observed only) |
| i_fsync | input | 1 | Frame sync (observed only) |
| i_sdata | input | 1 | Serial data |
| i_fmt | input | 4 | Framing style and mode code |
| i_wlen | input | 2 | Word-length code |
| i_slen | input | 2 | Slot-width code |
| i_offs | input | NCH*OFF_W | Per-channel byte offsets, 6 bits per channel |
| o_samples | output | NCH*SAMP_W | Four MSB-aligned samples |
| o_valid | output | 1 | One-cycle pulse when new samples are presented |

## Verification
The only timed result is the frame commit: the valid pulse and the new samples are due exactly three system-clock edges after the bit-clock rise that carries bit 0 of the following frame. The bench therefore records that due cycle each time it drives such a rise, together with the samples it expects, which it derives from the words it placed in each slot. On every other clock it requires valid to be low and the samples unchanged. A missing, late or early commit fails at that exact cycle. After each case a drain period confirms that no expected frame is still pending.

// File: rtl/arx_pkg.sv
package arx_pkg;

  localparam logic [3:0] FC_I2S    = 4'd8;
  localparam logic [3:0] FC_LEFT   = 4'd9;
  localparam logic [3:0] FC_RIGHT  = 4'd10;
  localparam logic [3:0] FC_LATE2  = 4'd11;
  localparam logic [3:0] FC_LATEN  = 4'd12;
  localparam logic [3:0] FC_EARLY2 = 4'd3;
  localparam logic [3:0] FC_EARLYN = 4'd4;

  function automatic logic fmt_known(input logic [3:0] f);
    return (f == FC_I2S) || (f == FC_LEFT) || (f == FC_RIGHT) || (f == FC_LATE2) ||
           (f == FC_LATEN) || (f == FC_EARLY2) || (f == FC_EARLYN);
  endfunction

  // frame begins on a falling sync edge
  function automatic logic fmt_falls(input logic [3:0] f);
    return f == FC_I2S;
  endfunction

  // first data bit one bit clock after the start edge
  function automatic logic fmt_late(input logic [3:0] f);
    return (f == FC_I2S) || (f == FC_LATE2) || (f == FC_LATEN);
  endfunction

  function automatic logic fmt_multi(input logic [3:0] f);
    return (f == FC_LATEN) || (f == FC_EARLYN);
  endfunction

  function automatic logic fmt_rjust(input logic [3:0] f);
    return f == FC_RIGHT;
  endfunction

  function automatic logic [5:0] slot_bits(input logic [1:0] c);
    case (c)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [5:0] word_bits(input logic [1:0] c, input logic [5:0] slot);
    logic [5:0] w;
    case (c)
      2'd0:    w = 6'd16;
      2'd1:    w = 6'd18;
      2'd2:    w = 6'd20;
      default: w = 6'd32;
    endcase
    return (w > slot) ? slot : w;
  endfunction

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
  parameter int W = 3
) (
  input  logic         i_clk,
  input  logic         i_rst,
  input  logic [W-1:0] i_d,
  output logic [W-1:0] o_q
);

  logic [W-1:0] stg1, stg2;

  always_ff @(posedge i_clk) begin
    if (i_rst) begin
      stg1 <= '0;
      stg2 <= '0;
    end else begin
      stg1 <= i_d;
      stg2 <= stg1;
    end
  end

  assign o_q = stg2;

endmodule

// File: rtl/arx_framer.sv
module arx_framer
  import arx_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             i_clk,
  input  logic             i_rst,
  input  logic             i_bclk,
  input  logic             i_fs,
  input  logic [3:0]       i_fmt,
  output logic             o_edge,
  output logic             o_bnd,
  output logic [CNT_W-1:0] o_idx
);

  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic             bclk_q;
  logic             fs_q;
  logic [CNT_W-1:0] pos;
  logic             late;
  logic             trig;
  logic             start;

  always_comb begin
    o_edge = i_bclk & ~bclk_q;
    late   = fmt_late(i_fmt);
    trig   = fmt_falls(i_fmt) ? (fs_q & ~i_fs) : (~fs_q & i_fs);
    start  = o_edge & fmt_known(i_fmt) & trig;
    o_idx  = (start & ~late) ? '0 : pos;
    o_bnd  = o_edge & (o_idx == '0);
  end

  always_ff @(posedge i_clk) begin
    if (i_rst) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
      pos    <= POS_MAX;
    end else begin
      bclk_q <= i_bclk;
      if (o_edge) begin
        fs_q <= i_fs;
        if (start)
          pos <= late ? '0 : CNT_W'(1);
        else if (pos != POS_MAX)
          pos <= pos + CNT_W'(1);
      end
    end
  end

  // R3: the bit index only moves on a bit-clock edge
  p_pos_hold_r3: assert property (@(posedge i_clk) disable iff (i_rst)
    !o_edge |=> $stable(pos));

  // R3: without a new start the index advances by one per bit clock
  p_pos_step_r3: assert property (@(posedge i_clk) disable iff (i_rst)
    (o_edge && !start && pos != POS_MAX) |=> (pos == $past(pos) + CNT_W'(1)));

endmodule

// File: rtl/arx_lane.sv
module arx_lane #(
  parameter int SAMP_W = 32,
  parameter int CNT_W  = 10,
  parameter int LW     = 6
) (
  input  logic              i_clk,
  input  logic              i_rst,
  input  logic              i_edge,
  input  logic              i_bnd,
  input  logic              i_commit,
  input  logic              i_sd,
  input  logic [CNT_W-1:0]  i_idx,
  input  logic [CNT_W-1:0]  i_start,
  input  logic [LW-1:0]     i_len,
  input  logic [LW-1:0]     i_len_old,
  output logic [SAMP_W-1:0] o_samp
);

  logic [SAMP_W-1:0] acc, base, acc_nx;
  logic [CNT_W:0]    stop;
  logic              in_win;
  logic [LW:0]       sh;

  always_comb begin
    stop   = {1'b0, i_start} + (CNT_W+1)'(i_len);
    in_win = (i_idx >= i_start) && ({1'b0, i_idx} < stop);
    base   = i_bnd ? '0 : acc;
    acc_nx = in_win ? ((base << 1) | SAMP_W'(i_sd)) : base;
    sh     = (LW+1)'(SAMP_W) - {1'b0, i_len_old};
  end

  always_ff @(posedge i_clk) begin
    if (i_rst) begin
      acc    <= '0;
      o_samp <= '0;
    end else if (i_edge) begin
      acc <= acc_nx;
      if (i_commit)
        o_samp <= acc << sh;
    end
  end

  // R7: the collector only moves on a bit-clock edge
  p_acc_hold_r7: assert property (@(posedge i_clk) disable iff (i_rst)
    !i_edge |=> $stable(acc));

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import arx_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int SAMP_W    = 32,
  parameter int MAX_FRAME = 512,
  localparam int OFF_W    = $clog2(MAX_FRAME / 8)
) (
  input  logic                  i_clk,
  input  logic                  i_rst,
  input  logic                  i_bclk,
  input  logic                  i_fsync,
  input  logic                  i_sdata,
  input  logic [3:0]            i_fmt,
  input  logic [1:0]            i_wlen,
  input  logic [1:0]            i_slen,
  input  logic [NCH*OFF_W-1:0]  i_offs,
  output logic [NCH*SAMP_W-1:0] o_samples,
  output logic                  o_valid
);

  localparam int CNT_W = $clog2(MAX_FRAME) + 1;
  localparam int LW    = 6;

  logic [2:0]           syn;
  logic                 edge_s, bnd;
  logic [CNT_W-1:0]     idx;
  logic                 seen;

  logic [3:0]           act_fmt, eff_fmt;
  logic [1:0]           act_wl, eff_wl, act_sl, eff_sl;
  logic [NCH*OFF_W-1:0] act_offs, eff_offs;
  logic [LW-1:0]        eff_s, eff_l, old_l;
  logic                 eff_multi;
  logic [CNT_W-1:0]     rj_adj;

  arx_sync #(.W(3)) u_sync (
    .i_clk (i_clk),
    .i_rst (i_rst),
    .i_d   ({i_bclk, i_fsync, i_sdata}),
    .o_q   (syn)
  );

  arx_framer #(.CNT_W(CNT_W)) u_framer (
    .i_clk  (i_clk),
    .i_rst  (i_rst),
    .i_bclk (syn[2]),
    .i_fs   (syn[1]),
    .i_fmt  (i_fmt),
    .o_edge (edge_s),
    .o_bnd  (bnd),
    .o_idx  (idx)
  );

  // settings for the frame starting now come straight from the inputs
  always_comb begin
    eff_fmt   = bnd ? i_fmt  : act_fmt;
    eff_wl    = bnd ? i_wlen : act_wl;
    eff_sl    = bnd ? i_slen : act_sl;
    eff_offs  = bnd ? i_offs : act_offs;
    eff_s     = slot_bits(eff_sl);
    eff_l     = word_bits(eff_wl, eff_s);
    old_l     = word_bits(act_wl, slot_bits(act_sl));
    eff_multi = fmt_multi(eff_fmt);
    rj_adj    = fmt_rjust(eff_fmt) ? CNT_W'(eff_s - eff_l) : '0;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    localparam bit ODD = (k % 2) == 1;
    logic [OFF_W-1:0] off_k;
    logic [CNT_W-1:0] base_k, start_k;

    always_comb begin
      off_k = eff_offs[k*OFF_W +: OFF_W];
      if (eff_multi)
        base_k = CNT_W'({off_k, 3'b000});
      else
        base_k = ODD ? CNT_W'(eff_s) : '0;
      start_k = base_k + rj_adj;
    end

    arx_lane #(.SAMP_W(SAMP_W), .CNT_W(CNT_W), .LW(LW)) u_lane (
      .i_clk     (i_clk),
      .i_rst     (i_rst),
      .i_edge    (edge_s),
      .i_bnd     (bnd),
      .i_commit  (bnd & seen),
      .i_sd      (syn[0]),
      .i_idx     (idx),
      .i_start   (start_k),
      .i_len     (eff_l),
      .i_len_old (old_l),
      .o_samp    (o_samples[k*SAMP_W +: SAMP_W])
    );
  end

  always_ff @(posedge i_clk) begin
    if (i_rst) begin
      seen     <= 1'b0;
      o_valid  <= 1'b0;
      act_fmt  <= '0;
      act_wl   <= '0;
      act_sl   <= '0;
      act_offs <= '0;
    end else begin
      o_valid <= bnd & seen;
      if (bnd) begin
        seen     <= 1'b1;
        act_fmt  <= i_fmt;
        act_wl   <= i_wlen;
        act_sl   <= i_slen;
        act_offs <= i_offs;
      end
    end
  end

  // R10: valid is a single-cycle pulse
  p_pulse_r10: assert property (@(posedge i_clk) disable iff (i_rst)
    o_valid |=> !o_valid);

  // R10: samples only change together with valid
  p_hold_r10: assert property (@(posedge i_clk) disable iff (i_rst)
    !$stable(o_samples) |-> o_valid);

  // R11: frame settings stay put between boundaries
  p_cfg_hold_r11: assert property (@(posedge i_clk) disable iff (i_rst)
    !bnd |=> $stable({act_fmt, act_wl, act_sl, act_offs}));

  // R5: the word never exceeds its slot
  p_word_fits_r5: assert property (@(posedge i_clk) disable iff (i_rst)
    eff_l <= eff_s);

endmodule

// File: tb/sim_tdm_slot_rx.sv
`timescale 1ns/1ps
module sim_tdm_slot_rx;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bclk = 1'b0, fs = 1'b0, sd = 1'b0;
  logic [3:0]   fmt = 4'd9;
  logic [1:0]   wlen = 2'd0, slen = 2'd0;
  logic [23:0]  offs = '0;
  logic [127:0] o_samples;
  logic         o_valid;

  int total = 0, bad = 0, cyc = 0;
  int due_q[$];
  logic [127:0] exp_q[$];
  logic [127:0] held = '0;
  string cur_tag = "R1";

  tdm_slot_rx u0 (
    .i_clk(clk), .i_rst(rst), .i_bclk(bclk), .i_fsync(fs), .i_sdata(sd),
    .i_fmt(fmt), .i_wlen(wlen), .i_slen(slen), .i_offs(offs),
    .o_samples(o_samples), .o_valid(o_valid)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // per-clock comparison against the scheduled commits
  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        if (o_valid !== 1'b1 || o_samples !== exp_q[0]) begin
          bad++;
          $display("FAIL %s commit: valid=%b samples=%h expected valid=1 samples=%h",
                   cur_tag, o_valid, o_samples, exp_q[0]);
        end
        held = exp_q[0];
        void'(due_q.pop_front());
        void'(exp_q.pop_front());
      end else if (o_valid !== 1'b0 || o_samples !== held) begin
        bad++;
        $display("FAIL %s hold: valid=%b samples=%h expected valid=0 samples=%h",
                 cur_tag, o_valid, o_samples, held);
      end
    end
  end

  function automatic int sbits(input int c);
    return (c == 0) ? 16 : (c == 1) ? 24 : 32;
  endfunction

  function automatic int wbits(input int c, input int s);
    int w;
    w = (c == 0) ? 16 : (c == 1) ? 18 : (c == 2) ? 20 : 32;
    return (w > s) ? s : w;
  endfunction

  function automatic logic fs_at(input int fc, input int p, input int f);
    if (fc == 8) return (p < f / 2) ? 1'b0 : 1'b1;
    if (fc == 11 || fc == 12 || fc == 3 || fc == 4) return p == 0;
    return p < f / 2;
  endfunction

  function automatic logic [23:0] pack(input int a, input int b, input int c, input int d);
    return {d[5:0], c[5:0], b[5:0], a[5:0]};
  endfunction

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] nextr();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic drive_edge(input logic fv, input logic dv, input bit push,
                            input logic [127:0] ev);
    @(negedge clk); bclk = 1'b0; fs = fv; sd = dv;
    @(negedge clk);
    @(negedge clk); bclk = 1'b1;
    if (push) begin
      due_q.push_back(cyc + 3);
      exp_q.push_back(ev);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; bclk = 1'b0; fs = 1'b0; sd = 1'b0;
    repeat (4) @(negedge clk);
    due_q.delete(); exp_q.delete(); held = '0;
    total++;
    if (o_valid !== 1'b0 || o_samples !== '0) begin
      bad++;
      $display("FAIL R1 reset: valid=%b samples=%h expected valid=0 samples=0",
               o_valid, o_samples);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_case(input int fc, input int wl, input int sl, input int ns,
                          input logic [23:0] o1, input int nfr, input int chg,
                          input logic [23:0] o2, input int wl2, input string tag);
    int s, l, f;
    bit late, known, multi, rj;
    logic [23:0] cur_o;
    logic [31:0] slot_w[16];
    logic fbits[512];
    logic [127:0] exp_now, exp_prev;
    do_reset();
    cur_tag = tag;
    fmt = fc[3:0]; wlen = wl[1:0]; slen = sl[1:0]; offs = o1; cur_o = o1;
    s = sbits(sl); l = wbits(wl, s); f = ns * s;
    late  = (fc == 8 || fc == 11 || fc == 12);
    known = late || fc == 9 || fc == 10 || fc == 3 || fc == 4;
    multi = (fc == 12 || fc == 4);
    rj    = (fc == 10);
    exp_prev = '0;
    repeat (3) drive_edge(fc == 8, 1'b0, 1'b0, '0);
    if (late) drive_edge(fs_at(fc, 0, f), 1'b0, 1'b0, '0);
    for (int fr = 0; fr <= nfr; fr++) begin
      for (int e = 0; e < f; e++) fbits[e] = 1'b0;
      for (int k = 0; k < ns; k++) begin
        logic [31:0] w;
        w = (fr == nfr) ? 32'd0 : nextr();
        if (l < 32) w = w & ((32'd1 << l) - 32'd1);
        slot_w[k] = w;
        for (int b = 0; b < l; b++)
          fbits[k * s + (rj ? s - l : 0) + b] = w[l - 1 - b];
      end
      for (int k = 0; k < 4; k++) begin
        int si;
        si = multi ? (int'(cur_o[k*6 +: 6]) * 8) / s : k % 2;
        exp_now[k*32 +: 32] = slot_w[si] << (32 - l);
      end
      for (int e = 0; e < ((fr == nfr) ? 2 : f); e++) begin
        int p;
        p = late ? (e + 1) % f : e;
        drive_edge(fs_at(fc, p, f), fbits[e], e == 0 && fr > 0 && known, exp_prev);
        if (fr == chg && e == f / 2) begin
          offs = o2; wlen = wl2[1:0];
        end
      end
      exp_prev = exp_now;
      if (fr == chg) begin
        l = wbits(wl2, s); cur_o = o2;
      end
    end
    repeat (8) @(negedge clk);
    total++;
    if (due_q.size() != 0) begin
      bad++;
      $display("FAIL %s drain: pending=%0d expected pending=0", tag, due_q.size());
    end
  endtask

  initial begin
    run_case(9,  3, 2, 2,  pack(0,0,0,0),    3, -1, '0, 0, "R2 R3 R8 R10 left-justified");
    run_case(8,  0, 0, 2,  pack(0,0,0,0),    3, -1, '0, 0, "R2 R3 R6 R8 falling-start");
    run_case(10, 1, 2, 2,  pack(0,0,0,0),    3, -1, '0, 0, "R9 R5 right-justified");
    run_case(11, 2, 1, 2,  pack(5,7,9,1),    3, -1, '0, 0, "R8 R3 late pulse two-channel");
    run_case(3,  3, 1, 2,  pack(0,0,0,0),    3, -1, '0, 0, "R5 R6 early pulse 24-bit");
    run_case(12, 2, 2, 8,  pack(12,0,28,12), 3, -1, '0, 0, "R7 R3 late pulse multi-slot");
    run_case(4,  3, 2, 16, pack(60,0,4,32),  2, -1, '0, 0, "R12 R7 512-bit frame");
    run_case(4,  2, 0, 4,  pack(0,2,4,6),    3, -1, '0, 0, "R5 word clamped to slot");
    run_case(12, 3, 2, 4,  pack(0,4,8,12),   3, 1, pack(12,8,4,0), 0, "R11 mid-frame change");
    run_case(5,  0, 0, 2,  pack(0,0,0,0),    3, -1, '0, 0, "R4 unknown code 5");
    run_case(0,  0, 0, 2,  pack(0,0,0,0),    2, -1, '0, 0, "R4 unknown code 0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule